// File: doc/BRIEF.md
# Audio Serial Port Clock Controller

This block owns the bit clock and the frame clock of a serial audio data port. As clock master it divides its own timebase down to a bit clock and a left/right frame clock. The division depends on a frame-rate ratio select (128 or 256 master-clock periods per frame) and on a short-pulse (DSP) frame format select. As clock slave it takes both clocks from the port pins, resynchronises them and follows them. In both roles it gives the receive and transmit datapaths one-cycle strobes: one strobe when to sample, one when to launch, and one at each frame start. Each side has its own bit-clock polarity control.

The block runs on one clock, `clk`, at twice the master-clock rate. This is what lets the DSP-format bit clock equal the master clock while every output stays a register. One master-clock period is therefore two `clk` cycles. A requested configuration that combines DSP format, the 128fs ratio and a word longer than 16 bits is refused: the error output rises and the clocking in use is kept. A power-down input forces the port idle.

Top module: `aud_clk_ctrl`

## Requirements
- R1: After reset the block is clock slave: `clk_oe` is 0 and `bclk_out`/`lrclk_out` are 0. With `cfg_master`=1 and `pdn`=0, `clk_oe` is 1 and the block drives both clocks. In slave role both clock outputs stay 0.
- R2: A receive strobe `rx_sample` marks each rising edge of the effective receive bit clock. A transmit strobe `tx_launch` marks each falling edge of the effective transmit bit clock. In master role a strobe is high in the `clk` cycle after the bit-clock output changes, so a receive frame holds one strobe per bit. In slave role a strobe is high on the third `clk` rising edge after the `bclk_in` edge.
- R3: `rx_bclk_inv`=1 moves the receive strobes to falling bit-clock edges. `tx_bclk_inv`=1 moves the transmit strobes to rising edges. Each control acts on its own side only.
- R4: Master, `cfg_ratio256`=0, `cfg_dsp`=0: each bit-clock half period is 2 `clk` cycles (MCLK/2).
- R5: Master, `cfg_ratio256`=1, `cfg_dsp`=0: each bit-clock half period is 4 `clk` cycles (MCLK/4).
- R6: Master with `cfg_dsp`=1: each bit-clock half period is 1 `clk` cycle (equal to MCLK), for either ratio.
- R7: Master frame period is 256 `clk` cycles (MCLK/128) when `cfg_ratio256`=0 and 512 cycles (MCLK/256) when it is 1, in every format.
- R8: `cfg_wlen` encodes 0=16, 1=20, 2=24, 3=32 bits. A request with `cfg_dsp`=1, `cfg_ratio256`=0 and `cfg_wlen`≠0 sets `cfg_err` one cycle later and leaves the running clocks unchanged. A legal request clears `cfg_err`.
- R9: While `pdn`=1, `bclk_out` and `lrclk_out` are 0, `clk_oe` is 0, and `rx_sample`, `tx_launch` and `frame_start` are never asserted.
- R10: The master frame clock rises at frame start. It is high for half the frame in non-DSP formats and for exactly one bit period in DSP format. Every frame-clock change coincides with a falling bit-clock edge.
- R11: A change of role, ratio or format restarts the dividers. The first complete bit-clock high phase after the change already has the new length.
- R12: `frame_start` pulses together with the receive strobe that first samples the frame clock high after it was low, so there is one pulse per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase at twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = clock master, 0 = clock slave |
| cfg_ratio256 | input | 1 | 1 = 256fs ratio, 0 = 128fs ratio |
| cfg_dsp | input | 1 | 1 = short-pulse (DSP) frame format |
| cfg_wlen | input | 2 | Word length code: 0=16, 1=20, 2=24, 3=32 bits |
| pdn | input | 1 | Power-down, 1 holds the port idle |
| rx_bclk_inv | input | 1 | Invert the bit-clock edge used by the receive side |
| tx_bclk_inv | input | 1 | Invert the bit-clock edge used by the transmit side |
| bclk_in | input | 1 | Bit clock from the pin (slave role) |
| lrclk_in | input | 1 | Frame clock from the pin (slave role) |
| bclk_out | output | 1 | Generated bit clock (master role) |
| lrclk_out | output | 1 | Generated frame clock (master role) |
| clk_oe | output | 1 | Output enable for both clock pins |
| cfg_err | output | 1 | Requested configuration is illegal |
| rx_sample | output | 1 | One-cycle receive sampling strobe |
| tx_launch | output | 1 | One-cycle transmit launch strobe |
| frame_start | output | 1 | One-cycle frame-start strobe |

## Verification
The hardest state to reach is the instant just after a configuration change. The old divider phase must vanish, and the first full bit-clock pulse must already carry the new length. The stimulus changes the ratio while the master is running, then starts measuring from the first toggle, so the partial run before it is discarded. The illegal-request path gets similar care: the bench first establishes a known running ratio, then requests the forbidden combination and measures that the half period has not moved. The strobe latency is pinned down by single isolated slave edges with each polarity combination. Randomised slave bursts and legal master configurations, drawn from a fixed seed, cover the counts.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  typedef enum logic [1:0] {
    WLEN_16 = 2'd0,
    WLEN_20 = 2'd1,
    WLEN_24 = 2'd2,
    WLEN_32 = 2'd3
  } wlen_e;

  typedef struct packed {
    logic master;
    logic r256;
    logic dsp;
  } clkcfg_t;

  // DSP format at the low ratio cannot carry words longer than 16 bits.
  function automatic logic cfg_illegal(input logic dsp, input logic r256,
                                       input logic [1:0] wlen);
    return dsp & ~r256 & (wlen != WLEN_16);
  endfunction

endpackage

// File: rtl/aud_cfg_ctrl.sv
module aud_cfg_ctrl
  import aud_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_master,
  input  logic       req_r256,
  input  logic       req_dsp,
  input  logic [1:0] req_wlen,
  output clkcfg_t    act_q,
  output logic       restart_q,
  output logic       err_q
);

  clkcfg_t req;
  logic    bad;

  always_comb begin
    req.master = req_master;
    req.r256   = req_r256;
    req.dsp    = req_dsp;
    bad        = cfg_illegal(req_dsp, req_r256, req_wlen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '{master: 1'b0, r256: 1'b1, dsp: 1'b0};
      restart_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q     <= bad;
      restart_q <= 1'b0;
      if (!bad && req != act_q) begin
        act_q     <= req;
        restart_q <= 1'b1;
      end
    end
  end

  // R8: a refused request leaves the active clocking as it was
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bad |=> (act_q == $past(act_q)));

  // R8: a refused request raises the error flag
  p_err_flag_r8: assert property (@(posedge clk) disable iff (rst)
    bad |=> err_q);

endmodule

// File: rtl/aud_mclk_div.sv
module aud_mclk_div
  import aud_clk_pkg::*;
#(
  parameter int BASE_RATIO = 128
)(
  input  logic    clk,
  input  logic    rst,
  input  logic    pdn,
  input  logic    restart,
  input  clkcfg_t cfg,
  output logic    bclk_q,
  output logic    lr_q
);

  // clk runs at 2x MCLK, so one frame is 2*ratio clk cycles
  localparam int PLO = 2 * BASE_RATIO;
  localparam int PHI = 4 * BASE_RATIO;
  localparam int PW  = $clog2(PHI);
  localparam logic [PW-1:0] LAST_LO = PW'(PLO - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(PHI - 1);
  localparam logic [PW-1:0] HALF_LO = PW'(PLO / 2);
  localparam logic [PW-1:0] HALF_HI = PW'(PHI / 2);

  logic [PW-1:0] phase_q, phase_nxt, last;
  logic [1:0]    shift;
  logic          hold, bclk_nxt, lr_nxt, clr_q;

  always_comb begin
    last      = cfg.r256 ? LAST_HI : LAST_LO;
    // half bit period = 2**shift clk cycles
    shift     = cfg.dsp ? 2'd0 : (cfg.r256 ? 2'd2 : 2'd1);
    phase_nxt = (phase_q == last) ? '0 : phase_q + PW'(1);
    bclk_nxt  = phase_nxt[shift];
    if (cfg.dsp)
      lr_nxt = phase_nxt < (PW'(2) << shift);
    else
      lr_nxt = phase_nxt < (cfg.r256 ? HALF_HI : HALF_LO);
    hold      = pdn | restart | ~cfg.master;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      // park on the last phase so the next step opens a fresh frame
      phase_q <= last;
      bclk_q  <= 1'b0;
      lr_q    <= 1'b0;
      clr_q   <= 1'b1;
    end else begin
      phase_q <= phase_nxt;
      bclk_q  <= bclk_nxt;
      lr_q    <= lr_nxt;
      clr_q   <= 1'b0;
    end
  end

  // R9 / R1: held dividers keep both clocks low
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!bclk_q && !lr_q));

  // R10: a running frame clock only moves with a falling bit clock
  p_lr_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (!clr_q && !$past(clr_q) && (lr_q != $past(lr_q))) |-> (!bclk_q && $past(bclk_q)));

endmodule

// File: rtl/aud_edge_strobe.sv
module aud_edge_strobe #(
  parameter int SYNC = 2
)(
  input  logic clk,
  input  logic rst,
  input  logic pdn,
  input  logic use_ext,
  input  logic ext_bclk,
  input  logic ext_lr,
  input  logic int_bclk,
  input  logic int_lr,
  input  logic rx_inv,
  input  logic tx_inv,
  output logic rx_q,
  output logic tx_q,
  output logic fs_q
);

  logic [SYNC-1:0] b_sync, l_sync;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          b_sync <= '0;
          l_sync <= '0;
        end else begin
          b_sync <= ext_bclk;
          l_sync <= ext_lr;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          b_sync <= '0;
          l_sync <= '0;
        end else begin
          b_sync <= {b_sync[SYNC-2:0], ext_bclk};
          l_sync <= {l_sync[SYNC-2:0], ext_lr};
        end
      end
    end
  endgenerate

  logic cur_b, cur_l, prev_b, lr_smp_q;
  logic rise, fall, rx_hit, tx_hit;

  always_comb begin
    cur_b  = use_ext ? b_sync[SYNC-1] : int_bclk;
    cur_l  = use_ext ? l_sync[SYNC-1] : int_lr;
    rise   = cur_b & ~prev_b;
    fall   = ~cur_b & prev_b;
    rx_hit = rx_inv ? fall : rise;
    tx_hit = tx_inv ? rise : fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_b   <= 1'b0;
      lr_smp_q <= 1'b0;
      rx_q     <= 1'b0;
      tx_q     <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      prev_b <= cur_b;
      if (rx_hit) lr_smp_q <= cur_l;
      rx_q <= rx_hit & ~pdn;
      tx_q <= tx_hit & ~pdn;
      fs_q <= rx_hit & cur_l & ~lr_smp_q & ~pdn;
    end
  end

  // R9: power-down silences every strobe
  p_no_strobe_pdn_r9: assert property (@(posedge clk) disable iff (rst)
    pdn |=> (!rx_q && !tx_q && !fs_q));

  // R3: with equal polarity the two sides never fire on one edge
  p_sides_split_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_q && tx_q) |-> ($past(rx_inv) != $past(tx_inv)));

  // R12: a frame start is always a receive sampling point
  p_fs_with_rx_r12: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> rx_q);

endmodule

// File: rtl/aud_clk_ctrl.sv
module aud_clk_ctrl
  import aud_clk_pkg::*;
#(
  parameter int BASE_RATIO  = 128,
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_master,
  input  logic       cfg_ratio256,
  input  logic       cfg_dsp,
  input  logic [1:0] cfg_wlen,
  input  logic       pdn,
  input  logic       rx_bclk_inv,
  input  logic       tx_bclk_inv,
  input  logic       bclk_in,
  input  logic       lrclk_in,
  output logic       bclk_out,
  output logic       lrclk_out,
  output logic       clk_oe,
  output logic       cfg_err,
  output logic       rx_sample,
  output logic       tx_launch,
  output logic       frame_start
);

  clkcfg_t act;
  logic    restart, int_bclk, int_lr, oe_q;

  aud_cfg_ctrl u_cfg (
    .clk        (clk),
    .rst        (rst),
    .req_master (cfg_master),
    .req_r256   (cfg_ratio256),
    .req_dsp    (cfg_dsp),
    .req_wlen   (cfg_wlen),
    .act_q      (act),
    .restart_q  (restart),
    .err_q      (cfg_err)
  );

  aud_mclk_div #(.BASE_RATIO(BASE_RATIO)) u_div (
    .clk     (clk),
    .rst     (rst),
    .pdn     (pdn),
    .restart (restart),
    .cfg     (act),
    .bclk_q  (int_bclk),
    .lr_q    (int_lr)
  );

  aud_edge_strobe #(.SYNC(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pdn      (pdn),
    .use_ext  (~act.master),
    .ext_bclk (bclk_in),
    .ext_lr   (lrclk_in),
    .int_bclk (int_bclk),
    .int_lr   (int_lr),
    .rx_inv   (rx_bclk_inv),
    .tx_inv   (tx_bclk_inv),
    .rx_q     (rx_sample),
    .tx_q     (tx_launch),
    .fs_q     (frame_start)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= act.master & ~pdn;
  end

  assign bclk_out  = int_bclk;
  assign lrclk_out = int_lr;
  assign clk_oe    = oe_q;

  // R1: pins not enabled one cycle on means clocks held low
  p_slave_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!act.master || pdn) |=> ##1 !bclk_out);

endmodule

// File: tb/aud_clk_ctrl_tb.sv
module aud_clk_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_master = 1'b0, cfg_ratio256 = 1'b1, cfg_dsp = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic pdn = 1'b1, rx_bclk_inv = 1'b0, tx_bclk_inv = 1'b0;
  logic bclk_in = 1'b0, lrclk_in = 1'b0;
  logic bclk_out, lrclk_out, clk_oe, cfg_err, rx_sample, tx_launch, frame_start;

  always #5 clk = ~clk;

  aud_clk_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_ratio256(cfg_ratio256),
    .cfg_dsp(cfg_dsp), .cfg_wlen(cfg_wlen), .pdn(pdn),
    .rx_bclk_inv(rx_bclk_inv), .tx_bclk_inv(tx_bclk_inv),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out),
    .lrclk_out(lrclk_out), .clk_oe(clk_oe), .cfg_err(cfg_err),
    .rx_sample(rx_sample), .tx_launch(tx_launch), .frame_start(frame_start)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // ---------------- monitor ----------------
  bit mon_on = 0, b_seen = 0, chk_lvl = 0;
  logic exp_lvl = 1'b1;
  logic pb = 1'b0, pl = 1'b0;
  int cyc = 0, run = 0;
  int hi_min, hi_max, lo_min, lo_max, first_hi, toggles;
  int lr_rises, last_rise, lr_per, lr_hi, rx_frame, rx_per_frame;
  int rx_n, tx_n, fs_n, align_bad, lvl_bad;

  task automatic clear_stats();
    b_seen = 0; run = 0; hi_min = 99999; hi_max = 0; lo_min = 99999; lo_max = 0;
    first_hi = 0; toggles = 0; lr_rises = 0; last_rise = 0; lr_per = 0; lr_hi = 0;
    rx_frame = 0; rx_per_frame = 0; rx_n = 0; tx_n = 0; fs_n = 0;
    align_bad = 0; lvl_bad = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      rx_n += int'(rx_sample);
      tx_n += int'(tx_launch);
      fs_n += int'(frame_start);
      rx_frame += int'(rx_sample);
      if (chk_lvl && rx_sample && bclk_out != exp_lvl) lvl_bad++;
      if (bclk_out != pb) begin
        toggles++;
        if (b_seen) begin
          if (pb) begin
            if (first_hi == 0) first_hi = run;
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end else begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
        end
        b_seen = 1;
        run = 1;
      end else begin
        run++;
      end
      if (lrclk_out != pl && b_seen && !(bclk_out == 1'b0 && pb == 1'b1)) align_bad++;
      if (lrclk_out && !pl) begin
        if (lr_rises > 0) begin
          lr_per = cyc - last_rise;
          rx_per_frame = rx_frame;
        end
        lr_rises++;
        last_rise = cyc;
        rx_frame = 0;
      end
      if (!lrclk_out && pl && lr_rises > 0) lr_hi = cyc - last_rise;
    end
    pb = bclk_out;
    pl = lrclk_out;
  end

  // ---------------- master runs ----------------
  task automatic run_master(input bit r256, input bit dsp, input bit rxi, input bit txi);
    int h, p, bits, hexp;
    h = dsp ? 1 : (r256 ? 4 : 2);
    p = r256 ? 512 : 256;
    bits = p / (2 * h);
    cfg_master = 1; cfg_ratio256 = r256; cfg_dsp = dsp; cfg_wlen = 2'd0;
    rx_bclk_inv = rxi; tx_bclk_inv = txi; pdn = 0;
    tick(12);
    clear_stats();
    chk_lvl = (h >= 2);
    exp_lvl = rxi ? 1'b0 : 1'b1;
    mon_on = 1;
    tick(3 * p + 20);
    mon_on = 0;
    chk_lvl = 0;
    check(clk_oe == 1'b1, "R1 master drives clocks", int'(clk_oe), 1);
    if (dsp) begin
      check(hi_min == 1 && hi_max == 1 && lo_max == 1, "R6 dsp half period", hi_max, 1);
    end else if (r256) begin
      check(hi_min == 4 && hi_max == 4 && lo_min == 4 && lo_max == 4, "R5 256fs half period", hi_max, 4);
    end else begin
      check(hi_min == 2 && hi_max == 2 && lo_min == 2 && lo_max == 2, "R4 128fs half period", hi_max, 2);
    end
    check(lr_per == p, "R7 frame period", lr_per, p);
    hexp = dsp ? 2 * h : p / 2;
    check(lr_hi == hexp, "R10 frame clock high time", lr_hi, hexp);
    check(align_bad == 0, "R10 frame edge on bclk fall", align_bad, 0);
    check(rx_per_frame == bits, "R2 receive strobes per frame", rx_per_frame, bits);
    check(rx_n - tx_n <= 1 && tx_n - rx_n <= 1, "R3 tx strobe count", tx_n, rx_n);
    check(lvl_bad == 0, "R3 rx strobe edge polarity", lvl_bad, 0);
    check(fs_n >= lr_rises - 1 && fs_n <= lr_rises + 1, "R12 master frame starts", fs_n, lr_rises);
  endtask

  // ---------------- slave helpers ----------------
  task automatic lat_check(input bit level, input bit rxi, input bit txi);
    logic r1, t1, r2, t2;
    logic rx_e, tx_e;
    rx_bclk_inv = rxi; tx_bclk_inv = txi;
    bclk_in = ~level;
    tick(8);
    @(posedge clk); #2;
    bclk_in = level;
    @(negedge clk);
    @(negedge clk); r1 = rx_sample; t1 = tx_launch;
    @(negedge clk); r2 = rx_sample; t2 = tx_launch;
    @(negedge clk);
    rx_e = level ^ rxi;
    tx_e = ~level ^ txi;
    check(!r1 && !t1 && !r2 && !t2, "R2 no early slave strobe", int'({r1, t1, r2, t2}), 0);
    check(rx_sample == rx_e, "R3 rx strobe after third edge", int'(rx_sample), int'(rx_e));
    check(tx_launch == tx_e, "R3 tx strobe after third edge", int'(tx_launch), int'(tx_e));
  endtask

  task automatic slave_burst(input int nbits, input int half, input int lrk, input bit rxi);
    int lr_exp = 0;
    rx_bclk_inv = rxi; tx_bclk_inv = 0;
    bclk_in = 0; lrclk_in = 0;
    tick(10);
    clear_stats();
    mon_on = 1;
    for (int b = 0; b < nbits; b++) begin
      bclk_in = 0;
      if (b > 0 && (b % lrk) == 0) begin
        lrclk_in = ~lrclk_in;
        if (lrclk_in) lr_exp++;
      end
      tick(half);
      bclk_in = 1;
      tick(half);
    end
    bclk_in = 0;
    tick(10);
    mon_on = 0;
    check(rx_n == nbits, "R2 slave receive strobes", rx_n, nbits);
    check(tx_n == nbits, "R2 slave transmit strobes", tx_n, nbits);
    check(fs_n == lr_exp, "R12 slave frame starts", fs_n, lr_exp);
    check(toggles == 0 && clk_oe == 1'b0, "R1 slave leaves pins undriven", toggles, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5EED_0A7C));
    clear_stats();
    tick(5);
    rst = 0;
    tick(3);
    check(clk_oe == 0 && bclk_out == 0 && lrclk_out == 0, "R1 reset is slave",
          int'({clk_oe, bclk_out, lrclk_out}), 0);
    check(cfg_err == 0, "R8 no error after reset", int'(cfg_err), 0);

    // slave role
    pdn = 0;
    for (int k = 0; k < 4; k++) begin
      lat_check(1'b1, k[0], k[1]);
      lat_check(1'b0, k[0], k[1]);
    end
    for (int k = 0; k < 4; k++) begin
      int half, lrk;
      half = 3 + int'($urandom_range(0, 3));
      lrk  = 3 + int'($urandom_range(0, 5));
      slave_burst(30 + int'($urandom_range(0, 20)), half, lrk, 1'($urandom_range(0, 1)));
    end

    // master directed
    run_master(1'b1, 1'b0, 1'b0, 1'b0);
    run_master(1'b0, 1'b0, 1'b1, 1'b0);
    run_master(1'b1, 1'b1, 1'b0, 1'b1);
    run_master(1'b1, 1'b0, 1'b1, 1'b1);

    // R11: restart on ratio change while running at 256fs
    @(posedge clk); #2;
    cfg_ratio256 = 0;
    tick(2);
    clear_stats();
    mon_on = 1;
    tick(60);
    mon_on = 0;
    check(first_hi == 2, "R11 first pulse after change", first_hi, 2);

    // R8: illegal request from a running 256fs I2S setup
    run_master(1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #2;
    cfg_dsp = 1; cfg_ratio256 = 0; cfg_wlen = 2'd2;
    tick(2);
    check(cfg_err == 1'b1, "R8 illegal flagged", int'(cfg_err), 1);
    clear_stats();
    mon_on = 1;
    tick(200);
    mon_on = 0;
    check(hi_max == 4 && lo_max == 4, "R8 clocking kept", hi_max, 4);
    cfg_wlen = 2'd0;
    tick(2);
    check(cfg_err == 1'b0, "R8 legal request clears flag", int'(cfg_err), 0);
    run_master(1'b0, 1'b1, 1'b0, 1'b0);

    // random legal master configurations
    for (int k = 0; k < 5; k++) begin
      bit r, d;
      r = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      run_master(r, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // R9: power-down while master
    pdn = 1;
    tick(3);
    clear_stats();
    mon_on = 1;
    tick(600);
    mon_on = 0;
    check(toggles == 0 && bclk_out == 0 && lrclk_out == 0, "R9 clocks static low", toggles, 0);
    check(rx_n == 0 && tx_n == 0 && fs_n == 0, "R9 no strobes", rx_n + tx_n + fs_n, 0);
    check(clk_oe == 0, "R9 pins released", int'(clk_oe), 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule